// File: doc/BRIEF.md
# Pair-Row Array Multiplier

This block multiplies an unsigned multiplier operand X by an unsigned multiplicand Y and returns the full-width product. The array has one row for each pair of multiplier bits, so an X of width n needs only n/2 rows instead of n. Each row forms (2·x_hi + x_lo)·Y. It does this by adding Y to a copy of Y moved up by one bit position, in a single rippled pass of identical bit cells. Each cell takes x_lo·y_j, x_hi·y_(j-1) and the incoming ripple carry. It gives out their three-input XOR as the sum bit and their majority as the next carry. This logic fits one lookup table and one step of a dedicated carry chain.

The row results are added in a chain of adders, with row k weighted by 4^k. If X has an odd width, a zero bit is added above its top bit before the bits are paired. The combinational product is captured in an output register when `mul_go` is high. `prod_ok` marks the cycle after each capture. When `mul_go` is low, the last product stays on `prod_out`.

Top module: `lutmul_array`

## Requirements
- R1: One clock edge after a cycle with `mul_go` = 1, `prod_out` equals the unsigned product of the `mul_x` and `mul_y` values sampled on that edge, with no truncation, across all operand values.
- R2: `prod_ok` at each clock edge takes the value that `mul_go` had on that edge, so it is high for exactly the cycles that follow a capture.
- R3: While `mul_go` is low, `prod_out` keeps its last value, whatever `mul_x` and `mul_y` do.
- R4: While `rst_n` is low, `prod_ok` is 0 and `prod_out` is 0.
- R5: A zero on either operand gives a product of 0.
- R6: When both operands are all ones, the result is (2^XW−1)·(2^YW−1), filling the top product bit without overflow.
- R7: With an odd multiplier width, the unpaired top bit of X is weighted correctly, so the product stays exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_go | input | 1 | Capture the product of the current operands |
| mul_x | input | XW | Unsigned multiplier, consumed two bits per row |
| mul_y | input | YW | Unsigned multiplicand |
| prod_ok | output | 1 | High in the cycle after a capture |
| prod_out | output | XW+YW | Registered full-width unsigned product |

## Verification
The bench builds two copies of the block. One uses XW=6, YW=6, so there are three full bit-pair rows. The other uses XW=5, YW=4, which exercises the zero-padded top pair. Both sizes are small enough that every operand pair is applied and compared with an arithmetic product worked out in the bench. This covers the zero and all-ones corners, and every carry pattern inside a row cell. Quiet cycles with changing operands then show that the captured product is held.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;

    // Majority of three: the ripple carry of one pair-row cell.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Three-input parity: the sum bit of one pair-row cell.
    function automatic logic par3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    // Width of X after padding to an even count of bits.
    function automatic int even_width(input int w);
        return w + (w % 2);
    endfunction

endpackage

// File: rtl/lutmul_row.sv
// One array row: (2*xhi + xlo) * y, rippled through YW+1 cells.
module lutmul_row #(
    parameter int YW = 8,
    localparam int RW = YW + 2
) (
    input  logic          xlo,
    input  logic          xhi,
    input  logic [YW-1:0] y,
    output logic [RW-1:0] row
);
    import lutmul_pkg::*;

    // Multiplicand with a zero guard bit on each side:
    // yg[j+1] = y[j], yg[0] = y[-1] = 0, yg[YW+1] = y[YW] = 0.
    logic [YW+1:0] yg;
    assign yg = {1'b0, y, 1'b0};

    always_comb begin
        logic rip;
        logic lo_term;
        logic hi_term;
        row = '0;
        rip = 1'b0;
        for (int j = 0; j <= YW; j++) begin
            lo_term = xlo & yg[j+1];
            hi_term = xhi & yg[j];
            row[j]  = par3(lo_term, hi_term, rip);
            rip     = maj3(lo_term, hi_term, rip);
        end
        row[RW-1] = rip;
    end

endmodule

// File: rtl/lutmul_accum.sv
// Chain of adders: row k enters with weight 4^k.
module lutmul_accum #(
    parameter int ROWS = 4,
    parameter int RW   = 10,
    parameter int SW   = 16
) (
    input  logic [ROWS*RW-1:0] rows_flat,
    output logic [SW-1:0]      total
);
    logic [SW-1:0] part [0:ROWS];

    assign part[0] = '0;

    for (genvar k = 0; k < ROWS; k++) begin : g_stage
        logic [SW-1:0] shifted;
        assign shifted    = SW'(rows_flat[k*RW +: RW]) << (2 * k);
        assign part[k+1]  = part[k] + shifted;
    end

    assign total = part[ROWS];

endmodule

// File: rtl/lutmul_array.sv
module lutmul_array #(
    parameter int XW = 8,
    parameter int YW = 8,
    localparam int PW = XW + YW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mul_go,
    input  logic [XW-1:0] mul_x,
    input  logic [YW-1:0] mul_y,
    output logic          prod_ok,
    output logic [PW-1:0] prod_out
);
    import lutmul_pkg::*;

    localparam int XP   = even_width(XW);
    localparam int ROWS = XP / 2;
    localparam int RW   = YW + 2;
    localparam int SW   = XP + YW;

    logic [XP-1:0]      x_pad;
    logic [ROWS*RW-1:0] rows_flat;
    logic [SW-1:0]      sum_full;
    logic [PW-1:0]      prod_next;

    assign x_pad = XP'(mul_x);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        lutmul_row #(.YW(YW)) u_row (
            .xlo (x_pad[2*r]),
            .xhi (x_pad[2*r+1]),
            .y   (mul_y),
            .row (rows_flat[r*RW +: RW])
        );
    end

    lutmul_accum #(.ROWS(ROWS), .RW(RW), .SW(SW)) u_accum (
        .rows_flat (rows_flat),
        .total     (sum_full)
    );

    assign prod_next = PW'(sum_full);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_ok  <= 1'b0;
            prod_out <= '0;
        end else begin
            prod_ok <= mul_go;
            if (mul_go) begin
                prod_out <= prod_next;
            end
        end
    end

endmodule

// File: rtl/lutmul_array_chk.sv
module lutmul_array_chk #(
    parameter int XW = 8,
    parameter int YW = 8,
    localparam int PW = XW + YW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mul_go,
    input logic [XW-1:0] mul_x,
    input logic [YW-1:0] mul_y,
    input logic          prod_ok,
    input logic [PW-1:0] prod_out
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prod_ok) |-> (prod_out == PW'($past(mul_x)) * PW'($past(mul_y))));

    // R2
    ok_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (prod_ok == $past(mul_go)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(mul_go)) |-> $stable(prod_out));

    // R5
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mul_go) && (($past(mul_x) == '0) || ($past(mul_y) == '0)))
        |-> (prod_out == '0));

endmodule

bind lutmul_array lutmul_array_chk #(.XW(XW), .YW(YW)) u_lutmul_array_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mul_go   (mul_go),
    .mul_x    (mul_x),
    .mul_y    (mul_y),
    .prod_ok  (prod_ok),
    .prod_out (prod_out)
);

// File: tb/lutmul_array_bench.sv
module lutmul_array_bench;

    localparam int AXW = 6;
    localparam int AYW = 6;
    localparam int BXW = 5;
    localparam int BYW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic              go_a = 1'b0;
    logic [AXW-1:0]    x_a = '0;
    logic [AYW-1:0]    y_a = '0;
    logic              ok_a;
    logic [AXW+AYW-1:0] p_a;

    logic              go_b = 1'b0;
    logic [BXW-1:0]    x_b = '0;
    logic [BYW-1:0]    y_b = '0;
    logic              ok_b;
    logic [BXW+BYW-1:0] p_b;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lutmul_array #(.XW(AXW), .YW(AYW)) u_lutmul_array (
        .clk(clk), .rst_n(rst_n), .mul_go(go_a), .mul_x(x_a), .mul_y(y_a),
        .prod_ok(ok_a), .prod_out(p_a)
    );

    lutmul_array #(.XW(BXW), .YW(BYW)) u_lutmul_array_odd (
        .clk(clk), .rst_n(rst_n), .mul_go(go_b), .mul_x(x_b), .mul_y(y_b),
        .prod_ok(ok_b), .prod_out(p_b)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int x, input int y, input int xmax, input int ymax, input string base);
        if (x == 0 || y == 0)         return "R5";
        if (x == xmax && y == ymax)   return "R6";
        return base;
    endfunction

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: outputs cleared while held in reset
        check(ok_a == 1'b0, "R4", ok_a, 0);
        check(p_a == '0, "R4", p_a, 0);
        check(ok_b == 1'b0, "R4", ok_b, 0);
        check(p_b == '0, "R4", p_b, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R5 / R6 on the even-width copy, every operand pair
        for (int x = 0; x < (1 << AXW); x++) begin
            for (int y = 0; y < (1 << AYW); y++) begin
                x_a = AXW'(x); y_a = AYW'(y); go_a = 1'b1;
                @(negedge clk);
                check(p_a == (AXW+AYW)'(x * y),
                      tag_of(x, y, (1 << AXW) - 1, (1 << AYW) - 1, "R1"), p_a, x * y);
                if (y == 0) check(ok_a == 1'b1, "R2", ok_a, 1);
            end
        end

        // R3 / R2: idle cycles with moving operands
        go_a = 1'b0; x_a = 6'd13; y_a = 6'd21;
        @(negedge clk);
        check(ok_a == 1'b0, "R2", ok_a, 0);
        for (int i = 0; i < 4; i++) begin
            x_a = AXW'(i * 7 + 3); y_a = AYW'(i * 11 + 5);
            @(negedge clk);
            check(p_a == 12'd3969, "R3", p_a, 3969);
        end

        // R7 on the odd-width copy, every operand pair
        for (int x = 0; x < (1 << BXW); x++) begin
            for (int y = 0; y < (1 << BYW); y++) begin
                x_b = BXW'(x); y_b = BYW'(y); go_b = 1'b1;
                @(negedge clk);
                check(p_b == (BXW+BYW)'(x * y),
                      tag_of(x, y, (1 << BXW) - 1, (1 << BYW) - 1, "R7"), p_b, x * y);
            end
        end
        go_b = 1'b0; x_b = 5'd17; y_b = 4'd3;
        repeat (2) @(negedge clk);
        check(p_b == 9'd465, "R3", p_b, 465);
        check(ok_b == 1'b0, "R2", ok_b, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule